// File: doc/BRIEF.md
# Smart-Card Slot Status and Interrupt Collector

This block gathers the fault and event conditions of a two-slot smart-card front end into a single 8-bit status byte. The host reads the byte through a one-cycle read strobe. Event bits that were latched are cleared by that read. The supervisor bit is handled differently: it clears only on a read made after the supply alarm pulse has gone away. All asynchronous inputs pass through a two-flop synchronizer before they are used.

The block drives an active-low interrupt line. The line is low while any protection, presence or overheat bit is held, or while the alarm pulse is present. The auxiliary-change bit pulls the line low only when its enable input is high. Whenever a critical bit becomes set, the block emits a one-cycle pulse that tells the session controller to drop its start bit. A spacing monitor flags a status read or a control write that follows the previous status read too closely.

Top module: `cardstat_irq_top`

## Requirements
- R1: The status byte has this layout. Bit 7 reads 0. Bit 6 is slot-2 protection and bit 5 is slot-1 protection. Bit 4 is the supervisor latch. Bit 3 is the slot-2 presence change and bit 2 is the slot-1 presence change. Bit 1 is the auxiliary-change bit and bit 0 is overheat.
- R2: A slot's protection bit is set while either that slot's supply-fault or reset-fault input is high.
- R3: A presence bit is set by either a rising or a falling level change on that slot's presence input.
- R4: The auxiliary-change bit is set by either edge of the auxiliary input, and it latches whether or not the auxiliary enable is high.
- R5: `irq_n_o` is low when bit 6, 5, 3, 2 or 0 is set. It is also low when bit 1 is set with `aux_irq_en_i` high, or while the synchronized alarm is high. Otherwise it is high.
- R6: A status read clears the latched event bits at the read edge. An event or a still-present fault detected in the read cycle leaves its bit set.
- R7: The supervisor bit is 1 after reset and is held at 1 while the alarm is high. A read during the alarm leaves it set. A read after the synchronized alarm has fallen clears it.
- R8: `start_clr_o` pulses for one cycle, in the cycle that bit 6, 5, 4, 3, 2 or 0 goes from 0 to 1. A newly set auxiliary bit produces no pulse.
- R9: `spacing_viol_o` pulses for one cycle after a status read or control write that comes fewer than `MIN_GAP_CYC` clock edges after the previous status read. Exactly `MIN_GAP_CYC` edges is legal, and control writes do not restart the spacing window.
- R10: After reset the outputs are: `status_o` = 8'h10, `irq_n_o` = 1, `start_clr_o` = 0, `spacing_viol_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flt_vcc_i | input | 2 | Per-slot supply-pin fault (bit 0 = slot 1) |
| flt_rst_i | input | 2 | Per-slot reset-pin fault (bit 0 = slot 1) |
| pres_i | input | 2 | Per-slot card presence level (bit 0 = slot 1) |
| ovht_i | input | 1 | Overheat flag |
| aux_irq_i | input | 1 | Auxiliary interrupt pin level |
| aux_irq_en_i | input | 1 | Lets the auxiliary-change bit drive the interrupt |
| alarm_i | input | 1 | Supply supervisor alarm pulse |
| stat_rd_i | input | 1 | One-cycle status read strobe |
| ctrl_wr_i | input | 1 | One-cycle control-register write strobe |
| status_o | output | 8 | Status byte |
| irq_n_o | output | 1 | Active-low interrupt |
| start_clr_o | output | 1 | One-cycle clear for the session start bit |
| spacing_viol_o | output | 1 | One-cycle read-spacing violation pulse |

## Verification
Each result has a fixed latency:
- A status bit appears after the third rising edge that follows an input change: two synchronizer flops, then the latch.
- The interrupt follows on the same cycle as the status bit. For the alarm path it follows one edge earlier.
- `start_clr_o` rises in the same cycle as the bit it reports.
- A read clears its bits at the read edge itself.
- The spacing flag appears after the edge of the offending strobe.

The bench drives inputs on falling edges and waits the exact number of falling edges before it compares. It times the read-collision case so that the detection cycle lands on the read edge. Pulses are counted on falling edges and the totals are compared one cycle later.

// File: rtl/cardstat_pkg.sv
package cardstat_pkg;
  localparam int STAT_W    = 8;
  localparam int POS_OVHT  = 0;
  localparam int POS_AUX   = 1;
  localparam int POS_PRES1 = 2;
  localparam int POS_PRES2 = 3;
  localparam int POS_SUPL  = 4;
  localparam int POS_PROT1 = 5;
  localparam int POS_PROT2 = 6;

  // bits whose setting drops the card session
  localparam logic [STAT_W-1:0] CRIT_MASK = 8'b0111_1101;
  // bits that always drive the interrupt
  localparam logic [STAT_W-1:0] IRQ_MASK  = 8'b0110_1101;

  // synchronizer vector layout
  localparam int SY_VCC   = 0;  // 2 bits
  localparam int SY_RST   = 2;  // 2 bits
  localparam int SY_PRES  = 4;  // 2 bits
  localparam int SY_OVHT  = 6;
  localparam int SY_AUX   = 7;
  localparam int SY_ALARM = 8;
  localparam int SY_W     = 9;

  function automatic bit is_edge_bit(int pos);
    return (pos == POS_AUX) || (pos == POS_PRES1) || (pos == POS_PRES2);
  endfunction

  function automatic logic gap_short(int unsigned elapsed, int unsigned min_gap);
    return elapsed < min_gap;
  endfunction
endpackage

// File: rtl/cardstat_sync.sv
module cardstat_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cardstat_evt_latch.sv
module cardstat_evt_latch #(
  parameter bit EDGE_MODE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rd_clr_i,
  output logic bit_o,
  output logic rise_o
);
  logic set_evt;
  logic bit_q;

  if (EDGE_MODE) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i;
    end
    assign set_evt = lvl_i ^ prev_q;
  end else begin : g_level
    assign set_evt = lvl_i;
  end

  // set has priority so an event in the read cycle is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= 1'b0;
    else         bit_q <= set_evt | (bit_q & ~rd_clr_i);
  end

  assign bit_o  = bit_q;
  assign rise_o = set_evt & ~bit_q;

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> bit_q);
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !set_evt) |=> !bit_q);
endmodule

// File: rtl/cardstat_gap_mon.sv
module cardstat_gap_mon
  import cardstat_pkg::*;
#(
  parameter int MIN_GAP_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  output logic viol_o
);
  localparam int CW = $clog2(MIN_GAP_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_GAP_CYC);

  logic [CW-1:0] cnt_q;
  logic          viol_q;
  logic          too_soon;

  assign too_soon = gap_short(32'(cnt_q), MIN_GAP_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= SAT;
      viol_q <= 1'b0;
    end else begin
      viol_q <= (rd_i | wr_i) & too_soon;
      if (rd_i)             cnt_q <= CW'(1);
      else if (cnt_q < SAT) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign viol_o = viol_q;

  a_r9_viol_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |-> $past(rd_i || wr_i));
  a_r9_spaced_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == SAT) |=> !viol_q);
endmodule

// File: rtl/cardstat_irq_top.sv
module cardstat_irq_top
  import cardstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_GAP_CYC = 100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  flt_vcc_i,
  input  logic [1:0]  flt_rst_i,
  input  logic [1:0]  pres_i,
  input  logic        ovht_i,
  input  logic        aux_irq_i,
  input  logic        aux_irq_en_i,
  input  logic        alarm_i,
  input  logic        stat_rd_i,
  input  logic        ctrl_wr_i,
  output logic [7:0]  status_o,
  output logic        irq_n_o,
  output logic        start_clr_o,
  output logic        spacing_viol_o
);
  logic [SY_W-1:0]   raw_w, syn_w;
  logic [6:0]        src_w;
  logic [6:0]        rise_w;
  logic [STAT_W-1:0] stat_w;
  logic              alarm_s;
  logic              supl_q;
  logic              clr_q;
  logic              irq_evt;

  assign raw_w = {alarm_i, aux_irq_i, ovht_i, pres_i, flt_rst_i, flt_vcc_i};

  cardstat_sync #(.W(SY_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_w), .q_o(syn_w)
  );

  assign src_w[POS_OVHT]  = syn_w[SY_OVHT];
  assign src_w[POS_AUX]   = syn_w[SY_AUX];
  assign src_w[POS_PRES1] = syn_w[SY_PRES];
  assign src_w[POS_PRES2] = syn_w[SY_PRES+1];
  assign src_w[POS_SUPL]  = syn_w[SY_ALARM];
  assign src_w[POS_PROT1] = syn_w[SY_VCC]   | syn_w[SY_RST];
  assign src_w[POS_PROT2] = syn_w[SY_VCC+1] | syn_w[SY_RST+1];
  assign alarm_s          = src_w[POS_SUPL];

  for (genvar i = 0; i < 7; i++) begin : g_bit
    if (i != POS_SUPL) begin : g_lat
      cardstat_evt_latch #(.EDGE_MODE(is_edge_bit(i))) u_lat (
        .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(src_w[i]),
        .rd_clr_i(stat_rd_i), .bit_o(stat_w[i]), .rise_o(rise_w[i])
      );
    end
  end

  // supervisor latch: set out of reset, held by alarm, cleared by a late read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        supl_q <= 1'b1;
    else if (alarm_s)   supl_q <= 1'b1;
    else if (stat_rd_i) supl_q <= 1'b0;
  end

  assign stat_w[POS_SUPL] = supl_q;
  assign rise_w[POS_SUPL] = alarm_s & ~supl_q;
  assign stat_w[7]        = 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= |(rise_w & CRIT_MASK[6:0]);
  end

  assign irq_evt = (|(stat_w & IRQ_MASK)) | (stat_w[POS_AUX] & aux_irq_en_i);

  assign status_o    = stat_w;
  assign irq_n_o     = ~(irq_evt | alarm_s);
  assign start_clr_o = clr_q;

  cardstat_gap_mon #(.MIN_GAP_CYC(MIN_GAP_CYC)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(stat_rd_i), .wr_i(ctrl_wr_i),
    .viol_o(spacing_viol_o)
  );

  a_r7_alarm_keeps_supl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_s |=> status_o[POS_SUPL]);
  a_r5_irq_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_o & IRQ_MASK)) |-> !irq_n_o);
  a_r5_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[6:0] == 7'd0 && !alarm_s) |-> irq_n_o);
  a_r8_clr_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_clr_o |-> (|(status_o & CRIT_MASK & ~$past(status_o))));
endmodule

// File: tb/cardstat_irq_top_tb.sv
module cardstat_irq_top_tb_top;
  localparam int GAP = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] vcc = '0, rstf = '0, pres = '0;
  logic       ovht = 0, aux = 0, aux_en = 0, alarm = 0, rd = 0, wr = 0;
  logic [7:0] status;
  logic       irq_n, start_clr, viol;

  int total = 0, bad = 0, clr_cnt = 0, viol_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cardstat_irq_top #(.SYNC_STAGES(2), .MIN_GAP_CYC(GAP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flt_vcc_i(vcc), .flt_rst_i(rstf),
    .pres_i(pres), .ovht_i(ovht), .aux_irq_i(aux), .aux_irq_en_i(aux_en),
    .alarm_i(alarm), .stat_rd_i(rd), .ctrl_wr_i(wr), .status_o(status),
    .irq_n_o(irq_n), .start_clr_o(start_clr), .spacing_viol_o(viol)
  );

  always @(negedge clk) begin
    if (start_clr) clr_cnt++;
    if (viol)      viol_cnt++;
  end

  // inputs[26:18] = {vcc[1:0], rst[1:0], pres[1:0], ovht, aux, en}
  // [17:10] status before read, [9] irq_n before, [8:1] status after, [0] irq_n after
  localparam logic [26:0] VECS [11] = '{
    {9'b01_00_00_000, 8'h20, 1'b0, 8'h20, 1'b0},
    {9'b00_00_00_000, 8'h20, 1'b0, 8'h00, 1'b1},
    {9'b00_10_00_000, 8'h40, 1'b0, 8'h40, 1'b0},
    {9'b00_00_01_000, 8'h44, 1'b0, 8'h00, 1'b1},
    {9'b00_00_00_010, 8'h06, 1'b0, 8'h00, 1'b1},
    {9'b00_00_00_000, 8'h02, 1'b1, 8'h00, 1'b1},
    {9'b00_00_00_011, 8'h02, 1'b0, 8'h00, 1'b1},
    {9'b00_00_10_111, 8'h09, 1'b0, 8'h01, 1'b0},
    {9'b00_00_10_001, 8'h03, 1'b0, 8'h00, 1'b1},
    {9'b10_01_10_000, 8'h60, 1'b0, 8'h60, 1'b0},
    {9'b00_00_00_000, 8'h68, 1'b0, 8'h00, 1'b1}
  };

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  task automatic do_write();
    wr = 1'b1; @(negedge clk); wr = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    int c0;
    wait_n(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 status", status, 8'h10);
    chk("R1 bit7 zero", status[7], 0);
    chk("R10 irq_n", irq_n, 1);
    chk("R10 start_clr", start_clr, 0);
    chk("R10 viol", viol, 0);

    // R7 supervisor behaviour
    alarm = 1; wait_n(3);
    chk("R5 alarm irq low", irq_n, 0);
    chk("R8 no clr when supl already set", clr_cnt, 0);
    do_read();
    chk("R7 read during alarm keeps supl", status, 8'h10);
    wait_n(GAP);
    alarm = 0; wait_n(3);
    chk("R5 irq high after alarm", irq_n, 1);
    chk("R7 supl still set before read", status, 8'h10);
    do_read();
    chk("R7 late read clears supl", status, 8'h00);
    wait_n(GAP);

    // table of patterns (R1..R6)
    for (int i = 0; i < 11; i++) begin
      logic [26:0] v;
      v = VECS[i];
      vcc = v[26:25]; rstf = v[24:23]; pres = v[22:21];
      ovht = v[20]; aux = v[19]; aux_en = v[18];
      wait_n(3);
      chk($sformatf("R2/R3/R4 vec%0d status", i), status, v[17:10]);
      chk($sformatf("R5 vec%0d irq_n", i), irq_n, v[9]);
      do_read();
      chk($sformatf("R6 vec%0d status after read", i), status, v[8:1]);
      chk($sformatf("R5 vec%0d irq_n after read", i), irq_n, v[0]);
      wait_n(GAP);
    end

    // R8 start-clear pulses
    aux_en = 0;
    c0 = clr_cnt;
    aux = 1; wait_n(3); settle();
    chk("R4 aux latched", status, 8'h02);
    chk("R8 aux gives no clr", clr_cnt, c0);
    do_read(); wait_n(GAP);
    ovht = 1; wait_n(3); settle();
    chk("R8 ovht gives one clr", clr_cnt, c0 + 1);
    ovht = 0; wait_n(3);
    do_read();
    chk("R6 ovht cleared", status, 8'h00);
    wait_n(GAP);
    alarm = 1; wait_n(3); settle();
    chk("R8 supl rise gives clr", clr_cnt, c0 + 2);
    alarm = 0; wait_n(3);
    do_read();
    chk("R7 supl cleared again", status, 8'h00);
    wait_n(GAP);

    // R6 event detected in the read cycle survives
    c0 = clr_cnt;
    pres = 2'b01; wait_n(2);
    do_read();
    chk("R6 event in read cycle kept", status, 8'h04);
    settle();
    chk("R8 presence clr", clr_cnt, c0 + 1);
    wait_n(GAP); do_read();
    chk("R6 later read clears", status, 8'h00);
    wait_n(GAP);

    // R9 spacing
    settle();
    chk("R9 no violations so far", viol_cnt, 0);
    do_read(); wait_n(GAP - 2); do_read(); settle();
    chk("R9 read one short", viol_cnt, 1);
    wait_n(GAP);
    do_read(); wait_n(GAP - 1); do_read(); settle();
    chk("R9 exact gap legal", viol_cnt, 1);
    wait_n(GAP);
    do_read(); wait_n(10); do_write(); settle();
    chk("R9 write after read", viol_cnt, 2);
    wait_n(GAP);
    do_write(); wait_n(5); do_write(); settle();
    chk("R9 write does not restart", viol_cnt, 2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule